// File: doc/BRIEF.md
# Load-pair sign-extending word executor

This block carries out one instruction that fetches two neighbouring 32-bit words from memory. Each word is widened to 64 bits by copying its sign bit, and the two results go to a pair of destination registers. A caller hands the block the 32-bit instruction word and the current value of the base register (a general register, or the stack pointer when the base field is 31). It also supplies two 2-bit policy codes that choose how register-overlap hazards are resolved. The block then reports everything the register file needs in a single-cycle completion pulse.

Internally the instruction is decoded and the hazards are classified. The block forms the access address for one of three indexing modes: offset applied before the access with the base updated, offset applied after the access, or offset applied with no update. It then issues two sequential reads on a valid/ready request port with a one-beat response. Undefined encodings, a misaligned stack pointer and error responses end the operation without any register write. "Unknown" results are driven as all zeros.

Top module: `pairload_unit`

## Requirements
- R1: The encoding is accepted only when bits 31:30 = 01, 29:27 = 101, 26 = 0, 25 = 0, 22 = 1 and bits 24:23 are not 00. Any other word completes with `flt_undef` = 1, no memory request and no register write.
- R2: The offset is bits 21:15 taken as a signed 7-bit value and multiplied by 4, covering -256 to +252 bytes.
- R3: Bits 24:23 select the mode: 01 reads at the unmodified base, while 11 and 10 read at base + offset.
- R4: Exactly two read requests are made, the second at the first address + 4. Each request holds `req_valid` and `req_addr` steady until `req_ready` is seen.
- R5: The first word, sign-extended to 64 bits, is written to the register in bits 4:0 (`wr1_*`). The second word, sign-extended, is written to the register in bits 14:10 (`wr2_*`).
- R6: Modes 01 and 11 write base + offset to the base register in bits 9:5 (`wb_*`). Mode 10 never writes the base.
- R7: When the base field is 31 and the base value's low 4 bits are not zero, the operation completes with `flt_align` = 1, with no request and no register write.
- R8: When writeback is on, the base field is not 31, and either destination equals the base, `pol_wb` decides the outcome: 0 drops the writeback, 1 writes a base value of zero, 2 reports `flt_undef`, and 3 completes as a no-op (`nop_done`) with no writes.
- R9: When both destination fields are equal, `pol_dup` decides the outcome: 0 performs the reads and writes zero to both destinations, 2 completes as a no-op, and 1 or 3 report `flt_undef`.
- R10: Checks apply in a fixed order: encoding first, then the R8 outcome, then the R9 outcome, and finally the R7 alignment check.
- R11: An error response on either read completes with `flt_bus` = 1 and no register write.
- R12: Every accepted `start` yields exactly one single-cycle `done`. A `start` seen while `busy` is high is ignored.
- R13: After reset, `done`, `req_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| instr | input | 32 | Instruction word |
| base_in | input | XLEN | Value of the selected base register or stack pointer |
| pol_wb | input | 2 | Policy for base/destination overlap |
| pol_dup | input | 2 | Policy for identical destinations |
| busy | output | 1 | Operation in progress |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | XLEN | Byte address of the word to read |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | WORD_W | Read data |
| rsp_err | input | 1 | Read response carries an error |
| done | output | 1 | One-cycle completion pulse |
| flt_undef | output | 1 | Completed as undefined |
| flt_align | output | 1 | Completed with stack-pointer alignment fault |
| flt_bus | output | 1 | Completed with read error |
| nop_done | output | 1 | Completed as a no-op |
| wr1_en | output | 1 | Write first destination |
| wr1_idx | output | 5 | First destination index |
| wr1_data | output | XLEN | First destination value |
| wr2_en | output | 1 | Write second destination |
| wr2_idx | output | 5 | Second destination index |
| wr2_data | output | XLEN | Second destination value |
| wb_en | output | 1 | Write the base register |
| wb_idx | output | 5 | Base register index (31 = stack pointer) |
| wb_data | output | XLEN | New base value |

## Verification
The bench sweeps all 128 immediates in all three modes, using two base values, with non-overlapping registers. The memory returns a word computed from its address, so a wrong address, a swapped word order or a lost sign extension each shows up as a distinct wrong value. The sweep runs under a request port that accepts at once and again under one that stalls. Further ops cover every policy code for both hazard types, every corrupted fixed bit, every misaligned low nibble of the stack pointer, combined hazards that separate the check order, and error responses on the first and on the second read.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 7;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_POST = 2'b01,
    MODE_OFFS = 2'b10,
    MODE_PRE  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_GO    = 2'd0,
    ACT_UNDEF = 2'd1,
    ACT_NOP   = 2'd2
  } act_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_REQ1, S_RSP1, S_REQ2, S_RSP2
  } st_e;

  typedef struct packed {
    logic             enc_ok;
    mode_e            mode;
    logic             wback;
    logic             post;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] rt2;
    logic [IDX_W-1:0] rn;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/pl_decode.sv
module pl_decode
  import pl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec.mode   = mode_e'(instr[24:23]);
    dec.enc_ok = (instr[31:30] == 2'b01) && (instr[29:27] == 3'b101) &&
                 !instr[26] && !instr[25] && instr[22] &&
                 (instr[24:23] != 2'b00);
    dec.wback  = (instr[24:23] == MODE_POST) || (instr[24:23] == MODE_PRE);
    dec.post   = (instr[24:23] == MODE_POST);
    dec.imm    = instr[21:15];
    dec.rt2    = instr[14:10];
    dec.rn     = instr[9:5];
    dec.rt     = instr[4:0];
  end
endmodule

// File: rtl/pl_hazard.sv
module pl_hazard
  import pl_pkg::*;
(
  input  logic             enc_ok,
  input  logic             wback,
  input  logic [IDX_W-1:0] rt,
  input  logic [IDX_W-1:0] rt2,
  input  logic [IDX_W-1:0] rn,
  input  logic [1:0]       pol_wb,
  input  logic [1:0]       pol_dup,
  output act_e             act,
  output logic             wb_en,
  output logic             wb_zero,
  output logic             data_zero
);
  localparam logic [IDX_W-1:0] SP_IDX = '1;

  logic wb_clash;
  assign wb_clash = wback && (rn != SP_IDX) && ((rt == rn) || (rt2 == rn));

  always_comb begin
    act       = ACT_GO;
    wb_en     = wback;
    wb_zero   = 1'b0;
    data_zero = 1'b0;
    if (!enc_ok) begin
      act   = ACT_UNDEF;
      wb_en = 1'b0;
    end else begin
      if (wb_clash) begin
        case (pol_wb)
          2'd0:    wb_en   = 1'b0;
          2'd1:    wb_zero = 1'b1;
          2'd2:    act     = ACT_UNDEF;
          default: act     = ACT_NOP;
        endcase
      end
      if ((act == ACT_GO) && (rt == rt2)) begin
        case (pol_dup)
          2'd0:    data_zero = 1'b1;
          2'd2:    act       = ACT_NOP;
          default: act       = ACT_UNDEF;
        endcase
      end
    end
  end
endmodule

// File: rtl/pl_agen.sv
module pl_agen
  import pl_pkg::*;
#(
  parameter int XLEN          = 64,
  parameter int WORD_W        = 32,
  parameter int IMM_SHIFT     = 2,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic             post,
  input  logic [IDX_W-1:0] rn,
  output logic [XLEN-1:0]  addr1,
  output logic [XLEN-1:0]  addr2,
  output logic [XLEN-1:0]  wb_val,
  output logic             misalign
);
  localparam logic [IDX_W-1:0] SP_IDX     = '1;
  localparam logic [XLEN-1:0]  WORD_BYTES = XLEN'(WORD_W / 8);

  logic [XLEN-1:0] off;
  logic [XLEN-1:0] upd;

  assign off      = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} << IMM_SHIFT;
  assign upd      = base + off;
  assign addr1    = post ? base : upd;
  assign addr2    = addr1 + WORD_BYTES;
  assign wb_val   = upd;
  assign misalign = (rn == SP_IDX) && (base[SP_ALIGN_BITS-1:0] != '0);
endmodule

// File: rtl/pairload_unit.sv
module pairload_unit
  import pl_pkg::*;
#(
  parameter int XLEN          = 64,
  parameter int WORD_W        = 32,
  parameter int IMM_SHIFT     = 2,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    base_in,
  input  logic [1:0]         pol_wb,
  input  logic [1:0]         pol_dup,
  output logic               busy,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [XLEN-1:0]    req_addr,
  input  logic               rsp_valid,
  input  logic [WORD_W-1:0]  rsp_data,
  input  logic               rsp_err,
  output logic               done,
  output logic               flt_undef,
  output logic               flt_align,
  output logic               flt_bus,
  output logic               nop_done,
  output logic               wr1_en,
  output logic [IDX_W-1:0]   wr1_idx,
  output logic [XLEN-1:0]    wr1_data,
  output logic               wr2_en,
  output logic [IDX_W-1:0]   wr2_idx,
  output logic [XLEN-1:0]    wr2_data,
  output logic               wb_en,
  output logic [IDX_W-1:0]   wb_idx,
  output logic [XLEN-1:0]    wb_data
);
  localparam int              EXT_W      = XLEN - WORD_W;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(WORD_W / 8);

  st_e               st;
  logic [INSTR_W-1:0] instr_q;
  logic [XLEN-1:0]    base_q;
  logic [1:0]         pw_q, pd_q;
  logic               wbe_q, wbz_q, dz_q;
  logic [XLEN-1:0]    a2_q, wbv_q;
  logic [WORD_W-1:0]  w1_q;

  dec_t            dec;
  act_e            act;
  logic            h_wb_en, h_wb_zero, h_dzero;
  logic [XLEN-1:0] ag_addr1, ag_addr2, ag_wb;
  logic            misalign;

  pl_decode u_dec (.instr(instr_q), .dec(dec));

  pl_hazard u_haz (
    .enc_ok(dec.enc_ok), .wback(dec.wback), .rt(dec.rt), .rt2(dec.rt2),
    .rn(dec.rn), .pol_wb(pw_q), .pol_dup(pd_q), .act(act),
    .wb_en(h_wb_en), .wb_zero(h_wb_zero), .data_zero(h_dzero)
  );

  pl_agen #(
    .XLEN(XLEN), .WORD_W(WORD_W), .IMM_SHIFT(IMM_SHIFT),
    .SP_ALIGN_BITS(SP_ALIGN_BITS)
  ) u_agen (
    .base(base_q), .imm(dec.imm), .post(dec.post), .rn(dec.rn),
    .addr1(ag_addr1), .addr2(ag_addr2), .wb_val(ag_wb), .misalign(misalign)
  );

  function automatic logic [XLEN-1:0] sext(input logic [WORD_W-1:0] w);
    return {{EXT_W{w[WORD_W-1]}}, w};
  endfunction

  assign busy = (st != S_IDLE);

  // register indices are fixed for the whole operation
  always_ff @(posedge clk) begin
    if (rst) begin
      wr1_idx <= '0;
      wr2_idx <= '0;
      wb_idx  <= '0;
    end else if (st == S_CHECK) begin
      wr1_idx <= dec.rt;
      wr2_idx <= dec.rt2;
      wb_idx  <= dec.rn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      instr_q   <= '0;
      base_q    <= '0;
      pw_q      <= '0;
      pd_q      <= '0;
      wbe_q     <= 1'b0;
      wbz_q     <= 1'b0;
      dz_q      <= 1'b0;
      a2_q      <= '0;
      wbv_q     <= '0;
      w1_q      <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      done      <= 1'b0;
      flt_undef <= 1'b0;
      flt_align <= 1'b0;
      flt_bus   <= 1'b0;
      nop_done  <= 1'b0;
      wr1_en    <= 1'b0;
      wr2_en    <= 1'b0;
      wb_en     <= 1'b0;
      wr1_data  <= '0;
      wr2_data  <= '0;
      wb_data   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            instr_q <= instr;
            base_q  <= base_in;
            pw_q    <= pol_wb;
            pd_q    <= pol_dup;
            st      <= S_CHECK;
          end
        end
        S_CHECK: begin
          wbe_q <= h_wb_en;
          wbz_q <= h_wb_zero;
          dz_q  <= h_dzero;
          a2_q  <= ag_addr2;
          wbv_q <= ag_wb;
          if ((act != ACT_GO) || misalign) begin
            done      <= 1'b1;
            flt_undef <= (act == ACT_UNDEF);
            nop_done  <= (act == ACT_NOP);
            flt_align <= (act == ACT_GO);
            flt_bus   <= 1'b0;
            wr1_en    <= 1'b0;
            wr2_en    <= 1'b0;
            wb_en     <= 1'b0;
            st        <= S_IDLE;
          end else begin
            req_valid <= 1'b1;
            req_addr  <= ag_addr1;
            st        <= S_REQ1;
          end
        end
        S_REQ1: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            st        <= S_RSP1;
          end
        end
        S_RSP1: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              done      <= 1'b1;
              flt_bus   <= 1'b1;
              flt_undef <= 1'b0;
              flt_align <= 1'b0;
              nop_done  <= 1'b0;
              wr1_en    <= 1'b0;
              wr2_en    <= 1'b0;
              wb_en     <= 1'b0;
              st        <= S_IDLE;
            end else begin
              w1_q      <= rsp_data;
              req_valid <= 1'b1;
              req_addr  <= a2_q;
              st        <= S_REQ2;
            end
          end
        end
        S_REQ2: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            st        <= S_RSP2;
          end
        end
        S_RSP2: begin
          if (rsp_valid) begin
            done      <= 1'b1;
            flt_undef <= 1'b0;
            flt_align <= 1'b0;
            nop_done  <= 1'b0;
            flt_bus   <= rsp_err;
            wr1_en    <= !rsp_err;
            wr2_en    <= !rsp_err;
            wb_en     <= !rsp_err && wbe_q;
            wr1_data  <= dz_q ? '0 : sext(w1_q);
            wr2_data  <= dz_q ? '0 : sext(rsp_data);
            wb_data   <= wbz_q ? '0 : wbv_q;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [XLEN-1:0] fire_addr_q;
  always_ff @(posedge clk) begin
    if (rst) fire_addr_q <= '0;
    else if (req_valid && req_ready) fire_addr_q <= req_addr;
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_second_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && st == S_REQ2) |-> (req_addr == fire_addr_q + WORD_BYTES));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fault_nowrite_R11: assert property (@(posedge clk) disable iff (rst)
    (done && (flt_undef || flt_align || flt_bus || nop_done)) |->
      (!wr1_en && !wr2_en && !wb_en));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot0({flt_undef, flt_align, flt_bus, nop_done}));

  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (done && wr1_en) |-> (wr1_data[XLEN-1:WORD_W] == {EXT_W{wr1_data[WORD_W-1]}}));

  assert_offs_nowb_R6: assert property (@(posedge clk) disable iff (rst)
    (done && dec.mode == MODE_OFFS) |-> !wb_en);

  assert_align_noreq_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHECK && misalign) |=> !req_valid);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !req_valid);
endmodule

// File: tb/pairload_unit_bench.sv
`timescale 1ns/1ps
module pairload_unit_bench;
  localparam int XLEN = 64;
  localparam int WORD_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] instr = '0;
  logic [XLEN-1:0] base_in = '0;
  logic [1:0] pol_wb = '0, pol_dup = '0;
  logic busy, req_valid, req_ready;
  logic [XLEN-1:0] req_addr;
  logic rsp_valid = 1'b0;
  logic [WORD_W-1:0] rsp_data = '0;
  logic rsp_err = 1'b0;
  logic done, flt_undef, flt_align, flt_bus, nop_done;
  logic wr1_en, wr2_en, wb_en;
  logic [4:0] wr1_idx, wr2_idx, wb_idx;
  logic [XLEN-1:0] wr1_data, wr2_data, wb_data;

  pairload_unit u_pairload_unit (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .base_in(base_in),
    .pol_wb(pol_wb), .pol_dup(pol_dup), .busy(busy), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .done(done), .flt_undef(flt_undef),
    .flt_align(flt_align), .flt_bus(flt_bus), .nop_done(nop_done),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
    .wr2_en(wr2_en), .wr2_idx(wr2_idx), .wr2_data(wr2_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, nreq = 0, ndone = 0, nbase = 0, err_sel = 0;
  logic stall_on = 1'b0;
  logic [1:0] rdy_cnt = '0;
  logic [XLEN-1:0] req_log [4];

  assign req_ready = stall_on ? (rdy_cnt != 2'd0) : 1'b1;

  function automatic logic [31:0] mem_word(input logic [XLEN-1:0] a);
    return a[31:0] ^ {a[15:0], a[31:16]} ^ 32'h8C3A_51E7;
  endfunction

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] m, input logic [6:0] imm,
                                     input logic [4:0] t2, input logic [4:0] n,
                                     input logic [4:0] t);
    return {2'b01, 3'b101, 1'b0, 1'b0, m, 1'b1, imm, t2, n, t};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdy_cnt <= rdy_cnt + 2'd1;
    if (done) ndone <= ndone + 1;
    rsp_valid <= 1'b0;
    rsp_err <= 1'b0;
    if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data <= mem_word(req_addr);
      rsp_err <= (err_sel != 0) && (err_sel == nreq - nbase + 1);
      req_log[nreq % 4] <= req_addr;
      nreq <= nreq + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: cycle %0d expected completion", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [31:0] ins, input logic [63:0] base,
                        input logic [1:0] pw, input logic [1:0] pd,
                        input int esel, input string tag);
    logic ok, wb, post, wbz, dz, und, nop, aln, bus;
    logic [4:0] t, t2, n;
    logic [63:0] off, a1, a2;
    int nexp, w;
    ok = ins[31:30] == 2'b01 && ins[29:27] == 3'b101 && !ins[26] && !ins[25] &&
         ins[22] && ins[24:23] != 2'b00;
    wb = ins[24:23] != 2'b10;
    post = ins[24:23] == 2'b01;
    t = ins[4:0]; n = ins[9:5]; t2 = ins[14:10];
    off = 64'(longint'($signed(ins[21:15])) * 4);
    wbz = 0; dz = 0; und = 0; nop = 0; aln = 0; bus = 0;
    if (!ok) und = 1;
    else begin
      if (wb && n != 31 && (t == n || t2 == n)) begin
        if (pw == 0) wb = 0;
        else if (pw == 1) wbz = 1;
        else if (pw == 2) und = 1;
        else nop = 1;
      end
      if (!und && !nop && t == t2) begin
        if (pd == 0) dz = 1;
        else if (pd == 2) nop = 1;
        else und = 1;
      end
      if (!und && !nop && n == 31 && base[3:0] != 0) aln = 1;
    end
    a1 = post ? base : base + off;
    a2 = a1 + 64'd4;
    nexp = (und || nop || aln) ? 0 : ((esel == 1) ? 1 : 2);
    bus = (esel != 0) && nexp > 0;

    @(negedge clk);
    instr = ins; base_in = base; pol_wb = pw; pol_dup = pd; err_sel = esel;
    nbase = nreq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 100) begin @(negedge clk); w++; end
    chk({tag, " done seen"}, 64'(done), 64'd1);
    chk({tag, " R10 undef"}, 64'(flt_undef), 64'(und));
    chk({tag, " R7 align"}, 64'(flt_align), 64'(aln));
    chk({tag, " R11 bus"}, 64'(flt_bus), 64'(bus));
    chk({tag, " R8 nop"}, 64'(nop_done), 64'(nop));
    chk({tag, " R4 nreq"}, 64'(nreq - nbase), 64'(nexp));
    if (nexp >= 1) chk({tag, " R3 addr1"}, req_log[nbase % 4], a1);
    if (nexp == 2) chk({tag, " R4 addr2"}, req_log[(nbase + 1) % 4], a2);
    if (!und && !nop && !aln && !bus) begin
      chk({tag, " R5 we1"}, 64'(wr1_en), 64'd1);
      chk({tag, " R5 idx1"}, 64'(wr1_idx), 64'(t));
      chk({tag, " R5 data1"}, wr1_data, dz ? 64'd0 : sx(mem_word(a1)));
      chk({tag, " R5 data2"}, wr2_data, dz ? 64'd0 : sx(mem_word(a2)));
      chk({tag, " R6 wb_en"}, 64'(wb_en), 64'(wb));
      if (wb) chk({tag, " R6 wb_data"}, wb_data, wbz ? 64'd0 : base + off);
    end else begin
      chk({tag, " R11 no writes"}, {61'd0, wr1_en, wr2_en, wb_en}, 64'd0);
    end
    @(negedge clk);
    chk({tag, " R12 pulse"}, 64'(done), 64'd0);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk("R13 done after reset", 64'(done), 64'd0);
    chk("R13 req_valid after reset", 64'(req_valid), 64'd0);
    chk("R13 busy after reset", 64'(busy), 64'd0);
    rst = 1'b0;

    // R2 R3 R4 R5 R6 sweep over every immediate, all modes, two bases
    for (int s = 0; s < 2; s++) begin
      stall_on = s[0];
      for (int m = 1; m < 4; m++)
        for (int i = 0; i < 128; i++) begin
          run_op(mk(2'(m), 7'(i), 5'd2, 5'd7, 5'd1), 64'h0000_7FFF_FFFF_FF00, 2'd0, 2'd0, 0, "R2 sweep A");
          run_op(mk(2'(m), 7'(i), 5'd9, 5'd3, 5'd4), 64'h8000_0000_0000_0040, 2'd0, 2'd0, 0, "R3 sweep B");
        end
    end
    stall_on = 1'b0;

    // R1 corrupt each fixed bit, and mode 00
    begin
      int bits [7] = '{31, 30, 29, 28, 27, 26, 25};
      for (int k = 0; k < 7; k++)
        run_op(mk(2'b11, 7'd3, 5'd2, 5'd5, 5'd1) ^ (32'd1 << bits[k]), 64'h1000, 0, 0, 0, "R1 bad bit");
      run_op(mk(2'b11, 7'd3, 5'd2, 5'd5, 5'd1) ^ (32'd1 << 22), 64'h1000, 0, 0, 0, "R1 bit22");
      run_op(mk(2'b00, 7'd3, 5'd2, 5'd5, 5'd1), 64'h1000, 0, 0, 0, "R1 mode00");
    end

    // R7 stack pointer alignment
    for (int lo = 0; lo < 16; lo++)
      run_op(mk(2'b11, 7'h7C, 5'd2, 5'd31, 5'd1), 64'h2000 + 64'(lo), 0, 0, 0, "R7 sp");
    run_op(mk(2'b01, 7'd5, 5'd2, 5'd31, 5'd31), 64'h3000, 2'd2, 0, 0, "R8 sp exempt");

    // R8 writeback overlap, every policy, both writeback modes, both positions
    for (int p = 0; p < 4; p++) begin
      run_op(mk(2'b11, 7'd6, 5'd2, 5'd8, 5'd8), 64'h4000, 2'(p), 0, 0, "R8 pre rt");
      run_op(mk(2'b01, 7'h70, 5'd8, 5'd8, 5'd3), 64'h4000, 2'(p), 0, 0, "R8 post rt2");
      run_op(mk(2'b10, 7'd6, 5'd2, 5'd8, 5'd8), 64'h4000, 2'(p), 0, 0, "R8 offs none");
    end

    // R9 identical destinations, every policy
    for (int p = 0; p < 4; p++) begin
      run_op(mk(2'b10, 7'd1, 5'd6, 5'd4, 5'd6), 64'h5000, 0, 2'(p), 0, "R9 dup offs");
      run_op(mk(2'b11, 7'h7F, 5'd6, 5'd4, 5'd6), 64'h5000, 0, 2'(p), 0, "R9 dup pre");
    end

    // R10 ordering between checks
    run_op(mk(2'b11, 7'd1, 5'd8, 5'd8, 5'd8), 64'h6000, 2'd3, 2'd1, 0, "R10 wbnop over dupundef");
    run_op(mk(2'b11, 7'd1, 5'd8, 5'd8, 5'd8), 64'h6000, 2'd1, 2'd2, 0, "R10 wbzero then dupnop");
    run_op(mk(2'b10, 7'd1, 5'd3, 5'd31, 5'd3), 64'h6004, 0, 2'd1, 0, "R10 dup over align");
    run_op(mk(2'b10, 7'd1, 5'd3, 5'd31, 5'd3), 64'h6004, 0, 2'd0, 0, "R10 align after dupzero");

    // R11 error responses
    run_op(mk(2'b11, 7'd2, 5'd2, 5'd5, 5'd1), 64'h7000, 0, 0, 1, "R11 err first");
    run_op(mk(2'b01, 7'd2, 5'd2, 5'd5, 5'd1), 64'h7000, 0, 0, 2, "R11 err second");
    stall_on = 1'b1;
    run_op(mk(2'b01, 7'd2, 5'd2, 5'd5, 5'd1), 64'h7000, 0, 0, 2, "R11 err second stall");
    stall_on = 1'b0;

    // R12 start while busy is ignored
    @(negedge clk);
    d0 = ndone;
    nbase = nreq; err_sel = 0;
    instr = mk(2'b10, 7'd4, 5'd2, 5'd5, 5'd1); base_in = 64'h8000;
    start = 1'b1;
    @(negedge clk);
    instr = mk(2'b10, 7'd20, 5'd2, 5'd5, 5'd1); base_in = 64'h9000;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R12 one done", 64'(ndone - d0), 64'd1);
    chk("R12 first addr kept", req_log[nbase % 4], 64'h8010);
    chk("R12 data kept", wr2_data, sx(mem_word(64'h8014)));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule